// File: doc/BRIEF.md
# Dual-Mode Asynchronous CPU Bus Slave

This block connects the 16-bit asynchronous bus of a host processor to the core-clock side of a peripheral controller. The host frames each access with an active-low select, a read strobe, and two write strobes. One write strobe covers the low byte and the other covers the high byte. The block brings these pins into the core clock through two-flop synchronizers. It turns each bus cycle into exactly one single-cycle request toward either the register file or the FIFO data port.

The bus format is fixed by a strap pin that is sampled on the first clock after reset is released. In the separate format, a 7-bit word address arrives on its own lines. In the multiplexed format, the data bus first carries the address, which is held by an address latch enable, and then carries the data. Accesses that decode to the FIFO data port can have their two bytes exchanged, under a control bit supplied by the register file. Register accesses are never exchanged.

Top module: `hostbus_slave`

## Requirements
- R1: While reset is held and right after it, no request output is asserted, `data_o` is 0, and `data_oe_o` is low while the strobes are idle.
- R2: The strap level on the first clock after reset release selects the format: 1 means multiplexed, 0 means separate. Later strap changes have no effect until the next reset.
- R3: In separate format, the request address is the word address on `addr_i`, which represents byte-address bits 7 down to 1.
- R4: In multiplexed format, the request address is `data_i[7:1]` as it stood on the bus when the address latch enable fell. `data_i[0]` and `addr_i` are ignored.
- R5: A write yields one request once all write strobes have been released. Byte enable bit 0 reflects the low-byte strobe and bit 1 reflects the high-byte strobe. The data is the bus word captured while the strobes were low.
- R6: A read yields one request on the synchronized start of the read strobe. `data_o` then holds the returned word until the next read.
- R7: `data_oe_o` is high exactly while select and read strobe are both low.
- R8: Word address 0x10 is the FIFO data port. Accesses to it raise `fifo_push_o` or `fifo_pop_o` instead of `reg_wr_o` or `reg_rd_o`.
- R9: With `swap_en_i` high, FIFO port data is byte-exchanged in both directions, and the FIFO write byte enables are exchanged too. Register data is never exchanged.
- R10: At most one request is active per cycle. A held read strobe pops exactly once, and each write cycle pushes exactly once.
- R11: Strobes that toggle while select is high produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_strap_i | input | 1 | Bus format strap: 1 multiplexed, 0 separate |
| cs_n_i | input | 1 | Active-low select |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_lo_n_i | input | 1 | Active-low low-byte write strobe |
| wr_hi_n_i | input | 1 | Active-low high-byte write strobe |
| ale_i | input | 1 | Address latch enable for multiplexed format |
| addr_i | input | 7 | Word address for separate format |
| data_i | input | 16 | Bus data in; carries the address first in multiplexed format |
| data_o | output | 16 | Read data toward the bus |
| data_oe_o | output | 1 | Bus output enable |
| swap_en_i | input | 1 | FIFO byte exchange enable |
| reg_wr_o | output | 1 | Register write request |
| reg_rd_o | output | 1 | Register read request |
| reg_addr_o | output | 7 | Register word address |
| reg_be_o | output | 2 | Register write byte enables |
| reg_wdata_o | output | 16 | Register write data |
| reg_rdata_i | input | 16 | Register read data, valid in the request cycle |
| fifo_push_o | output | 1 | FIFO port write request |
| fifo_pop_o | output | 1 | FIFO port read request |
| fifo_be_o | output | 2 | FIFO write byte enables after any exchange |
| fifo_wdata_o | output | 16 | FIFO write data after any exchange |
| fifo_rdata_i | input | 16 | FIFO head word, valid in the pop cycle |

## Verification
The following properties are checked on every cycle:
- at most one request is active at a time;
- every request is a single-cycle pulse;
- writes carry at least one byte enable;
- the strapped format stays constant after its sampling clock;
- `data_o` changes only right after a read request.

Other behaviours can only be shown by the bench's scenarios:
- address selection in each format;
- byte-enable mapping;
- routing to the FIFO port;
- byte exchange in each direction;
- ignoring accesses without select;
- ignoring the strap after reset.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  parameter int unsigned HBS_AW = 7;
  parameter int unsigned HBS_DW = 16;
  localparam int unsigned HBS_BYTES = HBS_DW / 8;

  typedef logic [HBS_DW-1:0]    word_t;
  typedef logic [HBS_AW-1:0]    waddr_t;
  typedef logic [HBS_BYTES-1:0] be_t;

  // reverse the byte lanes of a word
  function automatic word_t swap_word(input word_t w);
    word_t r;
    for (int i = 0; i < HBS_BYTES; i++)
      r[i*8 +: 8] = w[(HBS_BYTES-1-i)*8 +: 8];
    return r;
  endfunction

  // reverse the byte enables the same way
  function automatic be_t swap_be(input be_t b);
    be_t r;
    for (int i = 0; i < HBS_BYTES; i++)
      r[i] = b[HBS_BYTES-1-i];
    return r;
  endfunction

  function automatic logic hits_port(input waddr_t a, input waddr_t port);
    return a == port;
  endfunction

  // exchange only on FIFO port traffic with swap enabled
  function automatic word_t lane_select(input word_t w, input logic fifo, input logic swap);
    return (fifo && swap) ? swap_word(w) : w;
  endfunction
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbs_addr_capture.sv
module hbs_addr_capture #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_i,
  input  logic          ale_a_i,
  input  logic [AW-1:0] sep_addr_i,
  input  logic [AW-1:0] mux_addr_i,
  output logic          mux_mode_o,
  output logic          strap_done_o,
  output logic [AW-1:0] cur_addr_o
);
  logic          mux_q;
  logic          done_q;
  logic [AW-1:0] lat_q;

  // format is taken once, on the first clock out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      mux_q  <= strap_i;
      done_q <= 1'b1;
    end
  end

  // follow the bus while the latch enable is high; the last value stays
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lat_q <= '0;
    else if (mux_q && ale_a_i)   lat_q <= mux_addr_i;
  end

  assign mux_mode_o   = mux_q;
  assign strap_done_o = done_q;
  assign cur_addr_o   = mux_q ? lat_q : sep_addr_i;
endmodule

// File: rtl/hbs_cycle_ctrl.sv
module hbs_cycle_ctrl #(
  parameter int unsigned BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_a_i,
  input  logic             rd_a_i,
  input  logic [BYTES-1:0] wr_a_i,
  output logic             rd_start_o,
  output logic             wr_capture_o,
  output logic             wr_done_o,
  output logic [BYTES-1:0] wr_be_o
);
  logic             rd_q;
  logic             armed_q;
  logic [BYTES-1:0] be_q;
  logic             rd_live;
  logic             wr_live;
  logic             wr_idle;

  assign rd_live = cs_a_i & rd_a_i;
  assign wr_live = cs_a_i & (|wr_a_i);
  assign wr_idle = ~(|wr_a_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_live;
  end

  // a write stays armed until every write strobe is released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      be_q    <= '0;
    end else if (wr_live) begin
      armed_q <= 1'b1;
      be_q    <= be_q | wr_a_i;
    end else if (armed_q && wr_idle) begin
      armed_q <= 1'b0;
      be_q    <= '0;
    end
  end

  assign rd_start_o   = rd_live & ~rd_q;
  assign wr_capture_o = wr_live;
  assign wr_done_o    = armed_q & wr_idle;
  assign wr_be_o      = be_q;
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hbs_pkg::*;
#(
  parameter int unsigned AW          = HBS_AW,
  parameter logic [AW-1:0] FIFO_WORD = 7'h10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_strap_i,
  input  logic          cs_n_i,
  input  logic          rd_n_i,
  input  logic          wr_lo_n_i,
  input  logic          wr_hi_n_i,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  input  word_t         data_i,
  output word_t         data_o,
  output logic          data_oe_o,
  input  logic          swap_en_i,
  output logic          reg_wr_o,
  output logic          reg_rd_o,
  output logic [AW-1:0] reg_addr_o,
  output be_t           reg_be_o,
  output word_t         reg_wdata_o,
  input  word_t         reg_rdata_i,
  output logic          fifo_push_o,
  output logic          fifo_pop_o,
  output be_t           fifo_be_o,
  output word_t         fifo_wdata_o,
  input  word_t         fifo_rdata_i
);
  localparam int unsigned ST_W  = 5;
  localparam int unsigned BUS_W = AW + HBS_DW;
  localparam logic [ST_W-1:0] ST_IDLE = 5'b01111;

  logic [ST_W-1:0]  st_q;
  logic [BUS_W-1:0] bus_q;
  logic [AW-1:0]    bus_addr_q;
  word_t            bus_data_q;

  logic             cs_a, rd_a, ale_a;
  be_t              wr_a;

  // named internal events
  logic             mux_mode_w;
  logic             strap_done_w;
  logic [AW-1:0]    cur_addr_w;
  logic             rd_start_w;
  logic             wr_capture_w;
  logic             wr_done_w;
  be_t              wr_be_w;
  logic             fifo_wr_hit_w;
  logic             fifo_rd_hit_w;

  logic [AW-1:0]    wr_addr_q;
  word_t            wdata_q;
  word_t            rd_hold_q;

  hbs_sync #(.W(ST_W), .STAGES(SYNC_STAGES), .RST_VAL(ST_IDLE)) u_strobe_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ale_i, wr_hi_n_i, wr_lo_n_i, rd_n_i, cs_n_i}),
    .q_o   (st_q)
  );

  // bus lines take the same depth so they align with the strobes
  hbs_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({addr_i, data_i}),
    .q_o   (bus_q)
  );

  assign bus_addr_q = bus_q[BUS_W-1:HBS_DW];
  assign bus_data_q = bus_q[HBS_DW-1:0];
  assign cs_a       = ~st_q[0];
  assign rd_a       = ~st_q[1];
  assign wr_a       = {~st_q[3], ~st_q[2]};
  assign ale_a      = st_q[4];

  hbs_addr_capture #(.AW(AW)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_i      (mode_strap_i),
    .ale_a_i      (ale_a),
    .sep_addr_i   (bus_addr_q),
    .mux_addr_i   (bus_data_q[AW:1]),
    .mux_mode_o   (mux_mode_w),
    .strap_done_o (strap_done_w),
    .cur_addr_o   (cur_addr_w)
  );

  hbs_cycle_ctrl #(.BYTES(HBS_BYTES)) u_cycle (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_a_i       (cs_a),
    .rd_a_i       (rd_a),
    .wr_a_i       (wr_a),
    .rd_start_o   (rd_start_w),
    .wr_capture_o (wr_capture_w),
    .wr_done_o    (wr_done_w),
    .wr_be_o      (wr_be_w)
  );

  // hold the address and data of the write while its strobes are low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wdata_q   <= '0;
    end else if (wr_capture_w) begin
      wr_addr_q <= cur_addr_w;
      wdata_q   <= bus_data_q;
    end
  end

  assign fifo_wr_hit_w = hits_port(wr_addr_q, FIFO_WORD);
  assign fifo_rd_hit_w = hits_port(cur_addr_w, FIFO_WORD);

  assign reg_wr_o    = wr_done_w & ~fifo_wr_hit_w;
  assign fifo_push_o = wr_done_w &  fifo_wr_hit_w;
  assign reg_rd_o    = rd_start_w & ~fifo_rd_hit_w;
  assign fifo_pop_o  = rd_start_w &  fifo_rd_hit_w;

  assign reg_addr_o   = wr_done_w ? wr_addr_q : cur_addr_w;
  assign reg_be_o     = wr_be_w;
  assign reg_wdata_o  = wdata_q;
  assign fifo_wdata_o = lane_select(wdata_q, 1'b1, swap_en_i);
  assign fifo_be_o    = swap_en_i ? swap_be(wr_be_w) : wr_be_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_hold_q <= '0;
    else if (rd_start_w) rd_hold_q <= fifo_rd_hit_w ? lane_select(fifo_rdata_i, 1'b1, swap_en_i)
                                                    : reg_rdata_i;
  end

  assign data_o    = rd_hold_q;
  assign data_oe_o = ~cs_n_i & ~rd_n_i;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker
  import hbs_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  reg_wr,
  input logic  reg_rd,
  input logic  push,
  input logic  pop,
  input be_t   reg_be,
  input logic  strap_done,
  input logic  mux_mode,
  input word_t data_o
);
  // R10: never two requests together
  p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd, push, pop}));

  // R10: one pop per held read strobe
  p_pop_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !pop);

  // R5: a write cycle produces a single pulse
  p_write_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || push) |=> !(reg_wr || push));

  // R5: register writes carry at least one byte
  p_be_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_be != '0));

  // R2: format fixed once sampled
  p_mode_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(mux_mode));

  // R6: read data moves only after a read request
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd || pop) |=> $stable(data_o));
endmodule

bind hostbus_slave hbs_checker u_hbs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr_o),
  .reg_rd     (reg_rd_o),
  .push       (fifo_push_o),
  .pop        (fifo_pop_o),
  .reg_be     (reg_be_o),
  .strap_done (strap_done_w),
  .mux_mode   (mux_mode_w),
  .data_o     (data_o)
);

// File: tb/hostbus_slave_bench.sv
`timescale 1ns/1ps
module hostbus_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_strap_i = 1'b0;
  logic        cs_n_i = 1'b1, rd_n_i = 1'b1, wr_lo_n_i = 1'b1, wr_hi_n_i = 1'b1, ale_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        data_oe_o;
  logic        swap_en_i = 1'b0;
  logic        reg_wr_o, reg_rd_o, fifo_push_o, fifo_pop_o;
  logic [6:0]  reg_addr_o;
  logic [1:0]  reg_be_o, fifo_be_o;
  logic [15:0] reg_wdata_o, fifo_wdata_o, reg_rdata_i;
  logic [15:0] fifo_rdata_i = 16'h12A5;

  localparam logic [6:0] FIFO_A = 7'h10;

  always #2 clk = ~clk;

  hostbus_slave u_hostbus_slave (
    .clk(clk), .rst_n(rst_n), .mode_strap_i(mode_strap_i),
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .wr_lo_n_i(wr_lo_n_i), .wr_hi_n_i(wr_hi_n_i),
    .ale_i(ale_i), .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .swap_en_i(swap_en_i), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .reg_addr_o(reg_addr_o),
    .reg_be_o(reg_be_o), .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i),
    .fifo_push_o(fifo_push_o), .fifo_pop_o(fifo_pop_o), .fifo_be_o(fifo_be_o),
    .fifo_wdata_o(fifo_wdata_o), .fifo_rdata_i(fifo_rdata_i)
  );

  // register file model: contents are a function of the address
  function automatic logic [15:0] reg_val(input logic [6:0] a);
    return {a, 2'b00, ~a};
  endfunction
  function automatic logic [15:0] bswap(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  assign reg_rdata_i = reg_val(reg_addr_o);
  always @(posedge clk) if (fifo_pop_o) fifo_rdata_i <= fifo_rdata_i + 16'h1111;

  typedef struct { int kind; logic [6:0] addr; logic [1:0] be; logic [15:0] data; } exp_t;
  exp_t exp_q[$];

  int   n_chk = 0, n_fail = 0;
  bit   mux = 1'b0;
  logic [15:0] exp_fw = 16'h12A5;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: kinds 0 reg write, 1 reg read, 2 push, 3 pop
  always @(negedge clk) begin : monitor
    int   kind;
    exp_t e;
    if (rst_n && (reg_wr_o || reg_rd_o || fifo_push_o || fifo_pop_o)) begin
      kind = reg_wr_o ? 0 : reg_rd_o ? 1 : fifo_push_o ? 2 : 3;
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 R11 unexpected request", kind, 4);
      end else begin
        e = exp_q.pop_front();
        check(kind == e.kind, "R8 request kind", kind, e.kind);
        if (kind <= 1)
          check(reg_addr_o == e.addr, mux ? "R4 address" : "R3 address", reg_addr_o, e.addr);
        if (kind == 0) begin
          check(reg_be_o == e.be, "R5 byte enables", reg_be_o, e.be);
          check(reg_wdata_o == e.data, "R5 R9 register write data", reg_wdata_o, e.data);
        end
        if (kind == 2) begin
          check(fifo_be_o == e.be, "R9 FIFO byte enables", fifo_be_o, e.be);
          check(fifo_wdata_o == e.data, "R9 FIFO write data", fifo_wdata_o, e.data);
        end
      end
    end
  end

  task automatic place_addr(input logic [6:0] a);
    if (mux) begin
      addr_i = ~a;                       // ignored in multiplexed format
      data_i = {8'h5A, a, 1'b1};         // bit 0 ignored
      ale_i  = 1'b1;
      tick(3);
      ale_i  = 1'b0;
      tick(3);
    end else begin
      addr_i = a;
      data_i = 16'hFFFF;
      tick(1);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [1:0] be, input logic [15:0] d, input bit sel);
    exp_t e;
    bit   f;
    f = (a == FIFO_A);
    if (sel) begin
      e.kind = f ? 2 : 0;
      e.addr = a;
      e.be   = (f && swap_en_i) ? {be[0], be[1]} : be;
      e.data = (f && swap_en_i) ? bswap(d) : d;
      exp_q.push_back(e);
    end
    place_addr(a);
    cs_n_i = !sel;
    data_i = d;
    tick(1);
    wr_lo_n_i = !be[0];
    wr_hi_n_i = !be[1];
    tick(4);
    wr_lo_n_i = 1'b1;
    wr_hi_n_i = 1'b1;
    tick(1);
    cs_n_i = 1'b1;
    tick(5);
  endtask

  task automatic bus_read(input logic [6:0] a, input logic [15:0] expd, input string req);
    exp_t e;
    e.kind = (a == FIFO_A) ? 3 : 1;
    e.addr = a;
    e.be   = '0;
    e.data = '0;
    exp_q.push_back(e);
    place_addr(a);
    cs_n_i = 1'b0;
    rd_n_i = 1'b0;
    tick(8);
    @(negedge clk);
    check(data_o == expd, req, data_o, expd);
    check(data_oe_o == 1'b1, "R7 drive during read", data_oe_o, 1);
    @(posedge clk); #1;
    rd_n_i = 1'b1;
    cs_n_i = 1'b1;
    @(negedge clk);
    check(data_oe_o == 1'b0, "R7 release after read", data_oe_o, 0);
    tick(4);
  endtask

  function automatic logic [15:0] next_fifo();
    logic [15:0] w;
    w = exp_fw;
    exp_fw = exp_fw + 16'h1111;
    return swap_en_i ? bswap(w) : w;
  endfunction

  task automatic do_reset(input bit strap);
    rst_n = 1'b0;
    mode_strap_i = strap;
    tick(3);
    @(negedge clk);
    check(!(reg_wr_o || reg_rd_o || fifo_push_o || fifo_pop_o), "R1 no request in reset", 0, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick(2);
    mode_strap_i = !strap;                // R2: late strap change ignored
    mux = strap;
    @(negedge clk);
    check(data_o == 16'h0, "R1 data after reset", data_o, 0);
    check(data_oe_o == 1'b0, "R1 output enable idle", data_oe_o, 0);
    check(!(reg_wr_o || reg_rd_o || fifo_push_o || fifo_pop_o), "R1 idle requests", 0, 0);
    tick(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    logic [15:0] fv;
    // separate format
    do_reset(1'b0);
    bus_write(7'h05, 2'b11, 16'h1234, 1'b1);   // R3 R5 full word
    bus_write(7'h06, 2'b01, 16'hBEEF, 1'b1);   // R5 low byte only
    bus_write(7'h07, 2'b10, 16'hC0DE, 1'b1);   // R5 high byte only
    bus_read(7'h05, reg_val(7'h05), "R6 register read data");
    bus_read(7'h33, reg_val(7'h33), "R6 second register read");

    // R11: strobes without select
    bus_write(7'h08, 2'b11, 16'h7777, 1'b0);
    addr_i = 7'h10;
    tick(1);
    rd_n_i = 1'b0;
    tick(8);
    @(negedge clk);
    check(data_oe_o == 1'b0, "R7 no drive without select", data_oe_o, 0);
    check(data_o == reg_val(7'h33), "R11 read data unchanged", data_o, reg_val(7'h33));
    @(posedge clk); #1;
    rd_n_i = 1'b1;
    tick(5);
    check(exp_q.size() == 0, "R11 no request without select", exp_q.size(), 0);

    // R8 FIFO port, no exchange
    swap_en_i = 1'b0;
    bus_write(FIFO_A, 2'b11, 16'hABCD, 1'b1);
    fv = next_fifo();
    bus_read(FIFO_A, fv, "R8 R10 FIFO pop data");

    // R9 exchange on
    swap_en_i = 1'b1;
    bus_write(FIFO_A, 2'b11, 16'hABCD, 1'b1);
    bus_write(FIFO_A, 2'b01, 16'h0055, 1'b1);
    fv = next_fifo();
    bus_read(FIFO_A, fv, "R9 FIFO pop exchanged");
    bus_write(7'h05, 2'b11, 16'h1234, 1'b1);   // register never exchanged
    bus_read(7'h05, reg_val(7'h05), "R9 register read not exchanged");

    // R2 R4 multiplexed format
    swap_en_i = 1'b0;
    do_reset(1'b1);
    bus_write(7'h2A, 2'b11, 16'h55AA, 1'b1);
    bus_write(FIFO_A, 2'b10, 16'h9876, 1'b1);
    bus_read(7'h2A, reg_val(7'h2A), "R4 multiplexed read data");
    fv = next_fifo();
    bus_read(FIFO_A, fv, "R8 multiplexed FIFO pop");
    swap_en_i = 1'b1;
    fv = next_fifo();
    bus_read(FIFO_A, fv, "R9 multiplexed FIFO pop exchanged");

    tick(4);
    check(exp_q.size() == 0, "R10 all expected requests seen", exp_q.size(), 0);
    finish_run();
  end
endmodule